// File: doc/BRIEF.md
# Receive Frame Queue

This block sits between a receive MAC and a host that collects frames by programmed I/O. The MAC presents a stream of bytes together with an end-of-frame marker and a 16-bit error-flag field. The block packs the bytes into 32-bit words in a data FIFO. When a frame completes, it pushes one status word into a separate, smaller FIFO. That word carries the byte length and the error flags.

The host polls a count word to see how many frames are pending. It pops the status word at the head and then pops `ceil(len/4)` data words. A frame becomes visible to the host only at its last byte. If a frame cannot be stored whole, it is dropped and its partial data is rewound. Three latched interrupt sources report three conditions: the status queue reaching a programmable level, a status-queue overflow and a data-FIFO overflow. These sources are cleared by a read strobe, masked per source and gated by a global enable. A flush input empties both FIFOs.

Top module: `rx_frame_queue`

## Requirements
- R1: Bytes are packed little-endian: the first byte of a frame goes to bits [7:0] of its first data word. A frame of `len` bytes occupies exactly `(len+3)/4` data words, and unused upper lanes of its last word read as zero.
- R2: A stored frame's status word is `{in_flags, len}`, with the byte length in bits [15:0] and the flags captured with the last byte in bits [31:16].
- R3: `sts_err` is 1 exactly when the head status word has any bit set under the mask 0xDF180000.
- R4: `cnt_word[31:16]` gives the number of queued status words and `cnt_word[15:0]` gives the number of readable data words. Both are zero after reset.
- R5: Data words of a frame still being received are not counted or readable. They become readable, together with the status word, in the cycle after the last byte is accepted.
- R6: If the status FIFO is full when a frame ends, the frame is discarded whole: no status word is stored, its data words are removed, and source bit 1 is latched. Frames already queued are unaffected.
- R7: If a data word cannot be written because the data FIFO is full, the frame is discarded whole and source bit 2 is latched. A following frame is stored normally.
- R8: Source bit 0 is latched whenever `af_level` is non-zero and the number of queued status words is at least `af_level`.
- R9: A cycle with `flush` high empties both FIFOs and abandons any partly received frame. MAC input is ignored during that cycle.
- R10: `src_rd` clears the latched sources, though a source that fires in the same cycle stays set. `irq` is `irq_gen` AND the OR of `irq_src & irq_en`.
- R11: A pop of an empty status or data FIFO has no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| flush | input | 1 | Empties both FIFOs |
| in_valid | input | 1 | MAC byte strobe |
| in_byte | input | 8 | MAC byte |
| in_last | input | 1 | Marks the final byte of a frame |
| in_flags | input | 16 | Error flags, sampled with the last byte |
| sts_pop | input | 1 | Pops the head status word |
| sts_word | output | 32 | Head status word |
| sts_err | output | 1 | Head status word shows a receive error |
| dat_pop | input | 1 | Pops the head data word |
| dat_word | output | 32 | Head data word |
| cnt_word | output | 32 | Pending frames (upper half) and readable data words (lower half) |
| af_level | input | SAW+1 | Status-queue almost-full level; 0 disables it |
| irq_en | input | 3 | Per-source interrupt enables |
| irq_gen | input | 1 | Global interrupt enable |
| src_rd | input | 1 | Read strobe that clears the sources |
| irq_src | output | 3 | Latched sources: bit 0 almost full, bit 1 status overflow, bit 2 data overflow |
| irq | output | 1 | Interrupt request |

## Verification
Suppose the committed and speculative write pointers drift apart, or a rewind is skipped. The lower half of `cnt_word` then disagrees with the sum of `(len+3)/4` over the queued frames. The first data word the host reads for the next frame also shows another frame's bytes. Both symptoms appear one cycle after the affected last byte. Likewise, a packing lane that is left stale shows as non-zero padding in the final word of the very next short frame. Frames of every length from 1 to 12 bytes are swept so that all four tail shapes are covered, and the two overflow kinds and flush are driven against a FIFO that already holds frames.

// File: rtl/rx_frame_queue.sv
module rx_frame_queue #(
  parameter int DDEPTH = 16,
  parameter int SDEPTH = 4,
  localparam int DAW = $clog2(DDEPTH),
  localparam int SAW = $clog2(SDEPTH)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          flush,
  input  logic          in_valid,
  input  logic [7:0]    in_byte,
  input  logic          in_last,
  input  logic [15:0]   in_flags,
  input  logic          sts_pop,
  output logic [31:0]   sts_word,
  output logic          sts_err,
  input  logic          dat_pop,
  output logic [31:0]   dat_word,
  output logic [31:0]   cnt_word,
  input  logic [SAW:0]  af_level,
  input  logic [2:0]    irq_en,
  input  logic          irq_gen,
  input  logic          src_rd,
  output logic [2:0]    irq_src,
  output logic          irq
);
  localparam logic [DAW:0] DFULL = (DAW+1)'(DDEPTH);
  localparam logic [SAW:0] SFULL = (SAW+1)'(SDEPTH);
  localparam logic [31:0] ERR_MASK = 32'hDF18_0000;

  logic [31:0] dmem [DDEPTH];
  logic [31:0] smem [SDEPTH];
  logic [DAW:0] wp, wc, rp;
  logic [SAW:0] sw, sr;
  logic [23:0] stage;
  logic [1:0]  lane;
  logic [15:0] blen;
  logic        drop;
  logic [2:0]  src;

  wire take    = in_valid & ~flush;
  wire fin     = take & in_last;
  wire [31:0] word = {8'h00, stage} | ({24'h0, in_byte} << (8 * lane));
  wire wr_word = take & ((lane == 2'd3) | in_last);
  wire dfull   = (wp - rp) == DFULL;
  wire d_ovf   = wr_word & ~drop & dfull;
  wire d_wr    = wr_word & ~drop & ~dfull;
  wire bad     = drop | d_ovf;
  wire [SAW:0] scount = sw - sr;
  wire s_full  = scount == SFULL;
  wire s_ovf   = fin & ~bad & s_full;
  wire s_push  = fin & ~bad & ~s_full;
  wire d_rd    = dat_pop & (wc != rp) & ~flush;
  wire s_rd    = sts_pop & (sw != sr) & ~flush;
  wire af      = (af_level != '0) & (scount >= af_level);
  wire [DAW:0] wp_inc = wp + (DAW+1)'(d_wr);

  always_ff @(posedge clk) begin
    if (d_wr) dmem[wp[DAW-1:0]] <= word;
    if (s_push) smem[sw[SAW-1:0]] <= {in_flags, 16'(blen + 16'd1)};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wp <= '0; wc <= '0; rp <= '0; sw <= '0; sr <= '0;
      stage <= '0; lane <= '0; blen <= '0; drop <= 1'b0;
    end else if (flush) begin
      wp <= '0; wc <= '0; rp <= '0; sw <= '0; sr <= '0;
      stage <= '0; lane <= '0; blen <= '0; drop <= 1'b0;
    end else begin
      rp <= rp + (DAW+1)'(d_rd);
      sr <= sr + (SAW+1)'(s_rd);
      sw <= sw + (SAW+1)'(s_push);
      if (fin) begin
        if (s_push) begin
          wp <= wp_inc;
          wc <= wp_inc;
        end else begin
          wp <= wc;
        end
        stage <= '0; lane <= '0; blen <= '0; drop <= 1'b0;
      end else if (take) begin
        wp    <= wp_inc;
        stage <= (lane == 2'd3) ? 24'h0 : word[23:0];
        lane  <= lane + 2'd1;
        blen  <= blen + 16'd1;
        drop  <= drop | d_ovf;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) src <= '0;
    else        src <= (src_rd ? 3'b000 : src) | {d_ovf, s_ovf, af};
  end

  assign sts_word = smem[sr[SAW-1:0]];
  assign sts_err  = |(sts_word & ERR_MASK);
  assign dat_word = dmem[rp[DAW-1:0]];
  assign cnt_word = {{(15-SAW){1'b0}}, scount, {(15-DAW){1'b0}}, DAW'(0) | (wc - rp)};
  assign irq_src  = src;
  assign irq      = irq_gen & |(src & irq_en);
endmodule

module rx_frame_queue_chk #(
  parameter int DDEPTH = 16,
  parameter int SDEPTH = 4
) (
  input logic        clk,
  input logic        rst_n,
  input logic        flush,
  input logic [31:0] cnt_word,
  input logic        irq_gen,
  input logic        irq
);
  a_r4_frames_bounded: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_word[31:16] <= 16'(SDEPTH));
  a_r4_words_bounded: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_word[15:0] <= 16'(DDEPTH));
  a_r5_one_frame_per_cycle: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> cnt_word[31:16] <= $past(cnt_word[31:16]) + 16'd1);
  a_r9_flush_empties: assert property (@(posedge clk) disable iff (!rst_n)
    flush |=> cnt_word == 32'h0);
  a_r10_irq_gated: assert property (@(posedge clk) disable iff (!rst_n)
    !irq_gen |-> !irq);
endmodule

bind rx_frame_queue rx_frame_queue_chk #(.DDEPTH(DDEPTH), .SDEPTH(SDEPTH)) u_chk (
  .clk(clk), .rst_n(rst_n), .flush(flush), .cnt_word(cnt_word),
  .irq_gen(irq_gen), .irq(irq));

// File: tb/rx_frame_queue_tb.sv
module rx_frame_queue_tb;
  localparam int DDEPTH = 16;
  localparam int SDEPTH = 4;
  localparam int SAW = 2;

  logic clk = 1'b0, rst_n = 1'b0, flush = 1'b0;
  logic in_valid = 1'b0, in_last = 1'b0;
  logic [7:0] in_byte = '0;
  logic [15:0] in_flags = '0;
  logic sts_pop = 1'b0, dat_pop = 1'b0, irq_gen = 1'b0, src_rd = 1'b0;
  logic [SAW:0] af_level = '0;
  logic [2:0] irq_en = '0;
  logic [31:0] sts_word, dat_word, cnt_word;
  logic sts_err, irq;
  logic [2:0] irq_src;
  int checks = 0, errors = 0;

  always #5 clk = ~clk;

  rx_frame_queue #(.DDEPTH(DDEPTH), .SDEPTH(SDEPTH)) u_dut (
    .clk(clk), .rst_n(rst_n), .flush(flush), .in_valid(in_valid), .in_byte(in_byte),
    .in_last(in_last), .in_flags(in_flags), .sts_pop(sts_pop), .sts_word(sts_word),
    .sts_err(sts_err), .dat_pop(dat_pop), .dat_word(dat_word), .cnt_word(cnt_word),
    .af_level(af_level), .irq_en(irq_en), .irq_gen(irq_gen), .src_rd(src_rd),
    .irq_src(irq_src), .irq(irq));

  function automatic logic [7:0] bv(int f, int i);
    return 8'(f * 37 + i * 11 + 1);
  endfunction

  function automatic logic [31:0] ew(int f, int len, int w);
    logic [31:0] r = '0;
    for (int k = 0; k < 4; k++)
      if (4 * w + k < len) r[8*k +: 8] = bv(f, 4 * w + k);
    return r;
  endfunction

  task automatic check(input string r, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", r, act, exp);
    end
  endtask

  task automatic drive(int f, int from, int to, int len, logic [15:0] fl);
    for (int i = from; i < to; i++) begin
      @(negedge clk);
      in_valid = 1'b1; in_byte = bv(f, i); in_last = (i == len - 1); in_flags = fl;
    end
    @(negedge clk);
    in_valid = 1'b0; in_last = 1'b0;
  endtask

  task automatic send(int f, int len, logic [15:0] fl);
    drive(f, 0, len, len, fl);
  endtask

  task automatic read_frame(int f, int len, logic [15:0] fl);
    check("R2 status word", sts_word, {fl, 16'(len)});
    check("R3 error flag", {31'h0, sts_err}, {31'h0, |({fl, 16'h0} & 32'hDF18_0000)});
    sts_pop = 1'b1;
    @(negedge clk);
    sts_pop = 1'b0;
    for (int w = 0; w < (len + 3) / 4; w++) begin
      check("R1 data word", dat_word, ew(f, len, w));
      dat_pop = 1'b1;
      @(negedge clk);
    end
    dat_pop = 1'b0;
  endtask

  task automatic clear_src();
    src_rd = 1'b1;
    @(negedge clk);
    src_rd = 1'b0;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    $display("FAIL watchdog actual=running expected=done");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    logic [15:0] fl;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    check("R4 reset count", cnt_word, 32'h0);
    check("R10 reset sources", {29'h0, irq_src}, 32'h0);
    check("R10 reset irq", {31'h0, irq}, 32'h0);

    for (int len = 1; len <= 12; len++) begin
      fl = (len % 3 == 0) ? 16'h2000 : (len % 3 == 1) ? 16'h0000 : 16'(len * 16'h1357 | 16'h0008);
      send(len, len, fl);
      check("R4 R1 count after frame", cnt_word, {16'd1, 16'((len + 3) / 4)});
      read_frame(len, len, fl);
      check("R4 count drained", cnt_word, 32'h0);
    end

    drive(40, 0, 5, 8, 16'h0001);
    check("R5 partial frame hidden", cnt_word, 32'h0);
    drive(40, 5, 8, 8, 16'h0001);
    check("R5 frame committed", cnt_word, {16'd1, 16'd2});
    read_frame(40, 8, 16'h0001);

    sts_pop = 1'b1; dat_pop = 1'b1;
    repeat (2) @(negedge clk);
    sts_pop = 1'b0; dat_pop = 1'b0;
    check("R11 empty pops ignored", cnt_word, 32'h0);
    send(41, 3, 16'h0);
    read_frame(41, 3, 16'h0);

    af_level = 3'd3; irq_en = 3'b111; irq_gen = 1'b1;
    clear_src();
    for (int f = 50; f < 53; f++) send(f, 4, 16'(f));
    @(negedge clk);
    check("R8 almost-full source", {31'h0, irq_src[0]}, 32'h1);
    check("R10 irq raised", {31'h0, irq}, 32'h1);
    send(53, 4, 16'(53));
    send(54, 4, 16'(54));
    check("R6 status overflow source", {31'h0, irq_src[1]}, 32'h1);
    check("R6 dropped frame rewound", cnt_word, {16'd4, 16'd4});
    for (int f = 50; f < 54; f++) read_frame(f, 4, 16'(f));
    check("R6 drained", cnt_word, 32'h0);
    clear_src();
    check("R10 read clears sources", {29'h0, irq_src}, 32'h0);
    check("R10 irq low after clear", {31'h0, irq}, 32'h0);

    send(60, 80, 16'h0);
    check("R7 oversize frame dropped", cnt_word, 32'h0);
    check("R7 data overflow source", {31'h0, irq_src[2]}, 32'h1);
    irq_gen = 1'b0;
    #1 check("R10 global gate", {31'h0, irq}, 32'h0);
    irq_gen = 1'b1; irq_en = 3'b011;
    #1 check("R10 source masked", {31'h0, irq}, 32'h0);
    irq_en = 3'b100;
    #1 check("R10 source enabled", {31'h0, irq}, 32'h1);
    send(61, 6, 16'h0040);
    read_frame(61, 6, 16'h0040);

    send(70, 5, 16'h0);
    send(71, 7, 16'h0);
    drive(72, 0, 3, 9, 16'h0);
    flush = 1'b1;
    @(negedge clk);
    flush = 1'b0;
    check("R9 flush empties", cnt_word, 32'h0);
    send(73, 7, 16'h8000);
    check("R9 count after flush", cnt_word, {16'd1, 16'd2});
    read_frame(73, 7, 16'h8000);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule